// File: doc/BRIEF.md
# Bipolar Receive Line Decoder with Violation Counter

This block sits at the receive end of a DS3/E3 line and turns the two-rail bipolar signal from the line interface back into one unipolar data stream. Each receive clock it samples a positive rail and a negative rail. Three decoding choices are available. It can remove the zero-substitution codes, with the three-zero form (B3ZS) or the four-zero form (HDB3) chosen by a select input. It can decode plain alternate mark inversion. It can bypass decoding and use the positive rail directly as non-return-to-zero data.

Any bipolar violation that is not part of a legal substitution counts as a line code violation. A bit time with both rails high also counts. In bypass mode the negative rail no longer carries data and acts as a count strobe from the line interface unit. The violation count saturates. A latch strobe copies the count into a holding register and clears the count, so a reader can collect it without losing events.

Top module: `rx_line_decoder`

## Requirements
- R1: With `nrz_en` high, `data_out` equals `rail_p` delayed by four clocks: a value sampled at edge k is output from edge k+3 until edge k+4. Bipolar decoding uses the same latency.
- R2: With `nrz_en` high, every cycle in which `rail_n` is high raises `lcv_pulse` one clock later and adds one to the count. A low `rail_n` adds nothing.
- R3: With `nrz_en` low and `ami_en` high, a mark on either rail decodes as 1 and a space decodes as 0. No substitution is removed, so a pulse with the same polarity as the previous pulse is decoded as 1 and flagged as a violation.
- R4: With `nrz_en` and `ami_en` low and `hdb3_sel` low, a same-polarity pulse whose previous bit time was a space is a substitution. That pulse, and the bit two positions before it, decode as 0 and are not counted.
- R5: With `hdb3_sel` high, a same-polarity pulse whose previous two bit times were spaces is a substitution. That pulse, and the bit three positions before it, decode as 0 and are not counted.
- R6: A same-polarity pulse that does not meet the substitution rule of the active mode decodes as 1 and is counted as a violation. The pattern +,0,+ is legal under R4 but is a violation under R5.
- R7: In any bipolar mode, both rails high in one bit time decodes as 1 and is counted. It does not change the polarity reference for the next pulse.
- R8: `ami_en` has no effect while `nrz_en` is high.
- R9: The first pulse after reset is never a violation, whatever its polarity.
- R10: The counter is CNT_W bits wide and holds at its maximum value. While `cnt_latch` is high, at the clock edge `cnt_hold` receives the count including that cycle's event and the counter clears. `cnt_hold` changes at no other time.
- R11: Reset drives `data_out`, `lcv_pulse` and `cnt_hold` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | receive clock |
| rst_n | input | 1 | active-low synchronous reset |
| rail_p | input | 1 | positive rail, or unipolar data in bypass mode |
| rail_n | input | 1 | negative rail, or violation strobe in bypass mode |
| nrz_en | input | 1 | bypass decoding (unipolar mode) |
| ami_en | input | 1 | plain alternate mark inversion decoding |
| hdb3_sel | input | 1 | 1: four-zero substitution, 0: three-zero substitution |
| cnt_latch | input | 1 | copy count to holding register and clear it |
| data_out | output | 1 | decoded unipolar data |
| lcv_pulse | output | 1 | one-clock flag per counted violation |
| cnt_hold | output | CNT_W | latched violation count |

## Verification
Random data is encoded by an independent model in the bench in each of the three bipolar forms and then decoded. Zero runs of three and four in the data force both the odd-parity and even-parity substitution shapes, so a wrong zero-run length or clear position shows up as corrupted data. Short hand-made patterns separate the modes. For example, +,0,+ must decode as all zeros under the three-zero code but as 1,0,1 with a violation under the four-zero code, and the same-polarity pair after two spaces must be counted under plain mark inversion. Bypass runs use a random positive rail with and without strobes on the negative rail, together with a long strobe burst, to show that the count saturates and that latching clears it.

// File: rtl/rx_line_decoder.sv
module rx_line_decoder #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rail_p,
  input  logic             rail_n,
  input  logic             nrz_en,
  input  logic             ami_en,
  input  logic             hdb3_sel,
  input  logic             cnt_latch,
  output logic             data_out,
  output logic             lcv_pulse,
  output logic [CNT_W-1:0] cnt_hold
);
  localparam int DEPTH = 4;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DEPTH-1:0] mark_q;
  logic             last_neg_q;
  logic             seen_q;
  logic [CNT_W-1:0] cnt_q;

  logic             single, both, viol, subst_ok, lcv_evt, in_bit;
  logic [CNT_W-1:0] cnt_inc;

  assign single   = rail_p ^ rail_n;
  assign both     = rail_p & rail_n;
  assign viol     = !nrz_en && single && seen_q && (rail_n == last_neg_q);
  // a violation after enough spaces closes a substitution code
  assign subst_ok = viol && !ami_en && !mark_q[0] && (!hdb3_sel || !mark_q[1]);
  assign lcv_evt  = nrz_en ? rail_n : (both || (viol && !subst_ok));
  assign in_bit   = nrz_en ? rail_p : ((rail_p | rail_n) && !subst_ok);
  assign cnt_inc  = (lcv_evt && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
  assign data_out = mark_q[DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mark_q     <= '0;
      last_neg_q <= 1'b0;
      seen_q     <= 1'b0;
      lcv_pulse  <= 1'b0;
      cnt_q      <= '0;
      cnt_hold   <= '0;
    end else begin
      mark_q[0] <= in_bit;
      mark_q[1] <= mark_q[0];
      mark_q[2] <= mark_q[1] && !(subst_ok && !hdb3_sel);
      mark_q[3] <= mark_q[2] && !(subst_ok && hdb3_sel);
      if (single && !nrz_en) begin
        last_neg_q <= rail_n;
        seen_q     <= 1'b1;
      end
      lcv_pulse <= lcv_evt;
      if (cnt_latch) begin
        cnt_hold <= cnt_inc;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end
endmodule

module rx_line_decoder_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rail_p,
  input logic             rail_n,
  input logic             nrz_en,
  input logic             cnt_latch,
  input logic             data_out,
  input logic             lcv_pulse,
  input logic [CNT_W-1:0] cnt_hold
);
  logic [2:0] warm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 3'd4) warm_q <= warm_q + 3'd1;
  end

  p_nrz_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 3'd4 && $past(nrz_en, 1) && $past(nrz_en, 2) && $past(nrz_en, 3) && $past(nrz_en, 4))
      |-> data_out == $past(rail_p, 4));

  p_nrz_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (nrz_en && rail_n) |=> lcv_pulse);

  p_nrz_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (nrz_en && !rail_n) |=> !lcv_pulse);

  p_both_rails_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!nrz_en && rail_p && rail_n) |=> lcv_pulse);

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_latch |=> $stable(cnt_hold));
endmodule

bind rx_line_decoder rx_line_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rail_p(rail_p), .rail_n(rail_n), .nrz_en(nrz_en),
  .cnt_latch(cnt_latch), .data_out(data_out), .lcv_pulse(lcv_pulse), .cnt_hold(cnt_hold)
);

// File: tb/tb_rx_line_decoder.sv
`timescale 1ns/1ps
module tb_rx_line_decoder;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rail_p = 1'b0, rail_n = 1'b0;
  logic nrz_en = 1'b0, ami_en = 1'b0, hdb3_sel = 1'b0, cnt_latch = 1'b0;
  logic data_out, lcv_pulse;
  logic [CNT_W-1:0] cnt_hold;

  always #10 clk = ~clk;

  rx_line_decoder #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .rail_p(rail_p), .rail_n(rail_n), .nrz_en(nrz_en),
    .ami_en(ami_en), .hdb3_sel(hdb3_sel), .cnt_latch(cnt_latch),
    .data_out(data_out), .lcv_pulse(lcv_pulse), .cnt_hold(cnt_hold)
  );

  typedef struct { bit chk; bit v; string req; } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;
  int dat[256];
  int sym[256];

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: the item pushed four drives ago is due now
  always @(posedge clk) begin
    #2;
    if (q.size() >= 4) begin
      item_t it;
      it = q.pop_front();
      if (it.chk) check(data_out == it.v, it.req, data_out, it.v);
    end
  end

  task automatic drive_sym(bit p, bit n, bit lat, bit expv, bit chk, int explcv, string req);
    @(negedge clk);
    rail_p = p; rail_n = n; cnt_latch = lat;
    q.push_back('{chk, expv, req});
    @(posedge clk); #2;
    if (explcv >= 0) check(lcv_pulse == explcv[0], req, lcv_pulse, explcv);
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) drive_sym(0, 0, 0, 0, 0, -1, "drain");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rail_p = 0; rail_n = 0; cnt_latch = 0;
    q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic fill(int n, int density);
    for (int i = 0; i < n; i++) dat[i] = ($urandom_range(0, 99) < density) ? 1 : 0;
  endtask

  // independent encoder: 0 plain inversion, 1 three-zero code, 2 four-zero code
  task automatic encode(int mode, int n);
    int last = -1, pulses = 0, z = 0, len;
    len = (mode == 2) ? 4 : 3;
    for (int i = 0; i < n; i++) begin
      if (dat[i] != 0) begin
        last = -last; sym[i] = last; pulses++; z = 0;
      end else begin
        sym[i] = 0; z++;
        if (mode != 0 && z == len) begin
          if (pulses % 2 == 1) sym[i] = last;
          else begin
            last = -last; sym[i-len+1] = last; sym[i] = last;
          end
          pulses = 0; z = 0;
        end
      end
    end
  endtask

  task automatic send_stream(int n, string req);
    for (int i = 0; i < n; i++)
      drive_sym(sym[i] > 0, sym[i] < 0, 0, dat[i] != 0, 1, 0, req);
    drain();
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    check(data_out == 0 && lcv_pulse == 0 && cnt_hold == 0, "R11", {data_out, lcv_pulse}, 0);
    do_reset();

    // R1 / R2: bypass data, no strobes
    nrz_en = 1;
    for (int i = 0; i < 40; i++) begin
      bit b = 1'($urandom_range(0, 1));
      drive_sym(b, 0, 0, b, 1, 0, "R1");
    end
    drain();

    // R8 / R2 / R10: ami_en set in bypass, strobes on negative rail, latch
    ami_en = 1; cnt = 0;
    for (int i = 0; i < 30; i++) begin
      bit b = 1'($urandom_range(0, 1));
      bit s = 1'($urandom_range(0, 1));
      cnt += s;
      drive_sym(b, s, 0, b, 1, s, "R8");
    end
    cnt += 1;
    drive_sym(1, 1, 1, 1, 1, 1, "R2");
    check(cnt_hold == cnt, "R10", cnt_hold, cnt);
    drain();
    check(cnt_hold == cnt, "R10", cnt_hold, cnt);

    // R3: plain inversion, random data then a same-polarity pair
    do_reset();
    nrz_en = 0; ami_en = 1;
    fill(64, 40); encode(0, 64); send_stream(64, "R3");
    do_reset();
    drive_sym(1, 0, 0, 1, 1, 0, "R3");
    drive_sym(0, 0, 0, 0, 1, 0, "R3");
    drive_sym(0, 0, 0, 0, 1, 0, "R3");
    drive_sym(1, 0, 0, 1, 1, 1, "R3");
    drain();

    // R4: three-zero code
    do_reset();
    ami_en = 0; hdb3_sel = 0;
    fill(120, 35); encode(1, 120); send_stream(120, "R4");
    do_reset();
    drive_sym(1, 0, 0, 0, 1, 0, "R4");
    drive_sym(0, 0, 0, 0, 1, 0, "R4");
    drive_sym(1, 0, 0, 0, 1, 0, "R4");
    drain();

    // R5: four-zero code
    do_reset();
    hdb3_sel = 1;
    fill(120, 35); encode(2, 120); send_stream(120, "R5");

    // R6: +,0,+ is a violation under the four-zero code
    do_reset();
    drive_sym(1, 0, 0, 1, 1, 0, "R6");
    drive_sym(0, 0, 0, 0, 1, 0, "R6");
    drive_sym(1, 0, 0, 1, 1, 1, "R6");
    drain();
    do_reset();
    hdb3_sel = 0;
    drive_sym(0, 1, 0, 1, 1, 0, "R6");
    drive_sym(0, 1, 0, 1, 1, 1, "R6");
    drain();

    // R7: both rails, polarity reference kept
    do_reset();
    ami_en = 1;
    drive_sym(1, 0, 0, 1, 1, 0, "R7");
    drive_sym(1, 1, 0, 1, 1, 1, "R7");
    drive_sym(0, 1, 0, 1, 1, 0, "R7");
    drain();

    // R9: first pulse negative is not a violation
    do_reset();
    drive_sym(0, 1, 0, 1, 1, 0, "R9");
    drive_sym(0, 1, 0, 1, 1, 1, "R9");
    drain();

    // R10: saturation and clear on latch
    do_reset();
    nrz_en = 1; ami_en = 0;
    for (int i = 0; i < 65540; i++) drive_sym(0, 1, 0, 0, 0, -1, "R10");
    drive_sym(0, 0, 1, 0, 0, 0, "R10");
    check(cnt_hold == 16'hFFFF, "R10", cnt_hold, 16'hFFFF);
    drive_sym(0, 0, 1, 0, 0, 0, "R10");
    check(cnt_hold == 0, "R10", cnt_hold, 0);
    drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule